// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. One outcome-history shift register is shared by every branch. The block joins that history with a few word-aligned address bits of the branch to select one 2-bit saturating counter in a pattern table. A lookup is combinational: the front end presents a branch address and gets a taken or not-taken guess in the same cycle. It also gets the history value that formed the index, and it keeps that value with the branch.

When the branch resolves, the back end sends the address, the real outcome and the saved history value. The block trains the counter that the prediction used and shifts the real outcome into the live history. After a mispredict, a restore input rebuilds the history from the saved value plus the correct outcome. This throws away the outcomes of branches fetched down the wrong path.

Both the lookup channel and the training channel use valid/ready. After reset the block sweeps the table, writing a starting value into each entry, and holds both ready outputs low until the sweep ends. A request offered while ready is low is not stored. The source must keep valid asserted until it sees ready. Once the sweep ends, ready stays high until the next reset, so the block applies no other back-pressure. With the default parameters the history is 8 bits wide and 2 address bits are used, giving 1024 counters. Setting the address width to 6 gives the 14-bit index and the 16K-entry table.

Top module: `gbp_predictor`

## Requirements
- R1: The table index is the history (upper part) concatenated with PC bits [ADDR_W+1:2] (lower part). PC bits 1:0 and every PC bit above ADDR_W+1 have no effect on which counter is selected.
- R2: In a cycle where the lookup is accepted, `pred_taken` is 1 when the selected counter holds 2 or 3 and 0 when it holds 0 or 1. The answer is combinational in the same cycle.
- R3: An accepted training request selects its counter from `upd_hist` and `upd_pc` by the rule in R1. A taken outcome increments that counter, stopping at 3. A not-taken outcome decrements it, stopping at 0. A counter never wraps.
- R4: An accepted training request without a restore makes the live history equal to {old history[HIST_W-2:0], outcome} on the next cycle. The oldest bit is dropped.
- R5: An accepted restore makes the history equal to {`fix_hist`[HIST_W-2:0], `fix_taken`} on the next cycle. If a training request is accepted in the same cycle, the restore decides the history and the counter is still trained.
- R6: After reset the history is zero and every counter holds 1 (weakly not taken). Both ready outputs stay low for 2^(HIST_W+ADDR_W) cycles while the table is filled. Training, restore and lookup requests made in that window change nothing.
- R7: When a lookup and a training request select the same counter in one cycle, the lookup returns the value the counter held before that cycle's training.
- R8: `pred_taken` is 0 whenever `pred_valid` or `pred_ready` is low. `pred_hist` always shows the live history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Lookup request present |
| pred_ready | output | 1 | Lookup accepted (high once the table fill has finished) |
| pred_pc | input | PC_W | Branch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Live global history, saved with the branch |
| upd_valid | input | 1 | Training request present |
| upd_ready | output | 1 | Training accepted |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_hist | input | HIST_W | History saved when the branch was predicted |
| fix_valid | input | 1 | Restore the history after a mispredict |
| fix_hist | input | HIST_W | History saved with the mispredicted branch |
| fix_taken | input | 1 | Correct outcome of the mispredicted branch |

## Verification
The assertions assume a synchronous active-low reset. They also assume that every address and history input is a known value whenever its valid input is high, and that `pred_pc` holds a known value at the cycle where the table fill ends. The bench drives every input from reset onward and never leaves a field at X. During the fill it deliberately holds all three request kinds active with non-zero data, to show that they are dropped. After the fill it sweeps every history and address combination through the restore path. It then trains with random outcomes and random history values, and it often selects the same counter for a lookup and a training request in one cycle.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

  localparam int CNT_W = 2;

  localparam logic [CNT_W-1:0] CNT_STRONG_NT = 2'd0;
  localparam logic [CNT_W-1:0] CNT_WEAK_NT   = 2'd1;
  localparam logic [CNT_W-1:0] CNT_WEAK_T    = 2'd2;
  localparam logic [CNT_W-1:0] CNT_STRONG_T  = 2'd3;

  typedef logic [CNT_W-1:0] ctr_t;

  // Saturating step: move one toward strong taken or strong not-taken.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CNT_STRONG_T) nxt = cur + 2'd1;
    end else begin
      if (cur != CNT_STRONG_NT) nxt = cur - 2'd1;
    end
    return nxt;
  endfunction

  // Direction is the counter's upper bit.
  function automatic logic ctr_dir(input ctr_t cur);
    return cur[CNT_W-1];
  endfunction

endpackage

// File: rtl/gbp_index.sv
module gbp_index #(
  parameter int HIST_W = 8,
  parameter int ADDR_W = 2,
  parameter int PC_W   = 32,
  parameter int ALIGN  = 2,
  localparam int IDX_W = HIST_W + ADDR_W
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [PC_W-1:0]   pc,
  output logic [IDX_W-1:0]  idx
);

  // History above, word-aligned address bits below.
  always_comb begin
    idx = {hist, pc[ALIGN +: ADDR_W]};
  end

endmodule

// File: rtl/gbp_history.sv
module gbp_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              fix_en,
  input  logic [HIST_W-1:0] fix_hist,
  input  logic              fix_bit,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (enable) begin
      if (fix_en) begin
        hist_q <= {fix_hist[HIST_W-2:0], fix_bit};
      end else if (shift_en) begin
        hist_q <= {hist_q[HIST_W-2:0], shift_bit};
      end
    end
  end

  assign hist = hist_q;

  // R4: a plain training step shifts its outcome in at bit 0
  a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && shift_en && !fix_en) |=>
      (hist == {$past(hist[HIST_W-2:0]), $past(shift_bit)}));

  // R5: a restore rebuilds the history and wins over a shift
  a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fix_en) |=> (hist == {$past(fix_hist[HIST_W-2:0]), $past(fix_bit)}));

  // R6: while the table fill runs, the history is held
  a_r6_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(hist));

endmodule

// File: rtl/gbp_pht.sv
module gbp_pht
  import gbp_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             ready,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output ctr_t             wr_old
);

  ctr_t             cnt_q [DEPTH];
  logic             filling_q;
  logic [IDX_W-1:0] fill_idx_q;

  // Fill sequencer: one entry per cycle after reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling_q  <= 1'b1;
      fill_idx_q <= '0;
    end else if (filling_q) begin
      fill_idx_q <= fill_idx_q + 1'b1;
      if (fill_idx_q == IDX_W'(DEPTH - 1)) filling_q <= 1'b0;
    end
  end

  // Single write port, shared by the fill and the training path.
  always_ff @(posedge clk) begin
    if (rst_n && filling_q) begin
      cnt_q[fill_idx_q] <= CNT_WEAK_NT;
    end else if (rst_n && wr_en) begin
      cnt_q[wr_idx] <= ctr_step(cnt_q[wr_idx], wr_taken);
    end
  end

  assign ready  = !filling_q;
  assign rd_cnt = cnt_q[rd_idx];
  assign wr_old = cnt_q[wr_idx];

  // R6: once the fill is over, ready stays high until reset
  a_r6_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R6: every entry starts weakly not taken
  a_r6_fill_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (rd_cnt == CNT_WEAK_NT));

  // R3: taken training moves up by one and stops at 3
  a_r3_up_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wr_en && wr_taken) |=>
      (cnt_q[$past(wr_idx)] == (($past(wr_old) == CNT_STRONG_T) ?
                                CNT_STRONG_T : $past(wr_old) + 2'd1)));

  // R3: not-taken training moves down by one and stops at 0
  a_r3_down_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wr_en && !wr_taken) |=>
      (cnt_q[$past(wr_idx)] == (($past(wr_old) == CNT_STRONG_NT) ?
                                CNT_STRONG_NT : $past(wr_old) - 2'd1)));

endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor
  import gbp_pkg::*;
#(
  parameter int HIST_W = 8,
  parameter int ADDR_W = 2,
  parameter int PC_W   = 32,
  localparam int IDX_W = HIST_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  output logic              pred_ready,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              fix_valid,
  input  logic [HIST_W-1:0] fix_hist,
  input  logic              fix_taken
);

  logic              tbl_ready;
  logic [HIST_W-1:0] live_hist;
  logic [IDX_W-1:0]  look_idx;
  logic [IDX_W-1:0]  train_idx;
  ctr_t              look_cnt;
  ctr_t              train_old;
  logic              upd_fire;

  assign upd_fire = upd_valid && tbl_ready;

  gbp_index #(.HIST_W(HIST_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_look_idx (
    .hist (live_hist),
    .pc   (pred_pc),
    .idx  (look_idx)
  );

  gbp_index #(.HIST_W(HIST_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_train_idx (
    .hist (upd_hist),
    .pc   (upd_pc),
    .idx  (train_idx)
  );

  gbp_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (tbl_ready),
    .rd_idx   (look_idx),
    .rd_cnt   (look_cnt),
    .wr_en    (upd_fire),
    .wr_idx   (train_idx),
    .wr_taken (upd_taken),
    .wr_old   (train_old)
  );

  gbp_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (tbl_ready),
    .shift_en (upd_fire),
    .shift_bit(upd_taken),
    .fix_en   (fix_valid),
    .fix_hist (fix_hist),
    .fix_bit  (fix_taken),
    .hist     (live_hist)
  );

  assign pred_ready = tbl_ready;
  assign upd_ready  = tbl_ready;
  assign pred_hist  = live_hist;
  assign pred_taken = pred_valid && tbl_ready && ctr_dir(look_cnt);

  // R8: no taken answer unless the lookup is accepted
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(pred_valid && pred_ready) |-> !pred_taken);

  // R6: both channels open and close together
  a_r6_ready_match: assert property (@(posedge clk) disable iff (!rst_n)
    pred_ready == upd_ready);

  // R2: a taken guess always comes from an upper-half counter
  a_r2_dir_msb: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> (look_cnt >= CNT_WEAK_T));

  // Unused training-path read kept only for the checks above
  logic unused_train_old;
  assign unused_train_old = ^train_old;

endmodule

// File: tb/gbp_predictor_bench.sv
`timescale 1ns/100ps
module gbp_predictor_bench;

  localparam int HIST_W = 8;
  localparam int ADDR_W = 2;
  localparam int PC_W   = 32;
  localparam int DEPTH  = 1 << (HIST_W + ADDR_W);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pred_valid = 1'b0;
  logic              pred_ready;
  logic [PC_W-1:0]   pred_pc = '0;
  logic              pred_taken;
  logic [HIST_W-1:0] pred_hist;
  logic              upd_valid = 1'b0;
  logic              upd_ready;
  logic [PC_W-1:0]   upd_pc = '0;
  logic              upd_taken = 1'b0;
  logic [HIST_W-1:0] upd_hist = '0;
  logic              fix_valid = 1'b0;
  logic [HIST_W-1:0] fix_hist = '0;
  logic              fix_taken = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int model [DEPTH];
  logic [HIST_W-1:0] m_hist;

  always #2 clk = ~clk;

  gbp_predictor #(.HIST_W(HIST_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_gbp_predictor (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist),
    .fix_valid(fix_valid), .fix_hist(fix_hist), .fix_taken(fix_taken)
  );

  function automatic int idx_of(input logic [HIST_W-1:0] h, input logic [PC_W-1:0] pc);
    return int'(h) * (1 << ADDR_W) + int'((pc >> 2) & ((1 << ADDR_W) - 1));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // Model of one accepted training and optional restore.
  task automatic model_train(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h,
                             input logic t, input logic fx, input logic [HIST_W-1:0] fh,
                             input logic ft);
    int i;
    i = idx_of(h, pc);
    if (t) begin
      if (model[i] < 3) model[i]++;
    end else begin
      if (model[i] > 0) model[i]--;
    end
    m_hist = fx ? {fh[HIST_W-2:0], ft} : {m_hist[HIST_W-2:0], t};
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 1;
    m_hist = '0;

    // R6: hold every request kind active through the fill
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    pred_valid = 1'b1;
    upd_valid = 1'b1; upd_taken = 1'b1; upd_hist = 8'h3C; upd_pc = 32'h10;
    fix_valid = 1'b1; fix_hist = 8'h55; fix_taken = 1'b1;
    #1;
    check("R6 pred_ready low in fill", pred_ready, 0);
    check("R6 upd_ready low in fill", upd_ready, 0);
    check("R8 pred_taken low while not ready", pred_taken, 0);
    for (int c = 0; c < DEPTH - 2; c++) @(negedge clk);
    #1;
    check("R6 still filling near end", pred_ready, 0);
    while (!pred_ready) @(negedge clk);
    upd_valid = 1'b0; fix_valid = 1'b0;
    #1;
    check("R6 history zero after fill", int'(pred_hist), 0);

    // R6/R1/R2: sweep every history and address through the restore path
    for (int h = 0; h < (1 << HIST_W); h++) begin
      @(negedge clk);
      fix_valid = 1'b1;
      fix_hist = HIST_W'(h >> 1);
      fix_taken = h[0];
      @(negedge clk);
      fix_valid = 1'b0;
      #0.2;
      check("R5 restored history", int'(pred_hist), h);
      for (int p = 0; p < (1 << ADDR_W); p++) begin
        pred_pc = (PC_W'(p) << 2) | PC_W'($urandom_range(3)) | (PC_W'($urandom) << 6);
        #0.3;
        check("R6 counter weakly not taken", pred_taken, 0);
      end
    end
    m_hist = 8'hFF;

    // R3/R5/R8: saturation walk on one counter; restore holds history at A5
    begin
      logic outs [10];
      int exp;
      outs = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 1};
      for (int s = 0; s < 10; s++) begin
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h0000_1008; upd_hist = 8'hA5; upd_taken = outs[s];
        fix_valid = 1'b1; fix_hist = 8'h52; fix_taken = 1'b1;
        model_train(upd_pc, upd_hist, upd_taken, 1'b1, fix_hist, fix_taken);
        @(negedge clk);
        upd_valid = 1'b0; fix_valid = 1'b0;
        pred_pc = 32'h0000_0008;
        #1;
        exp = model[idx_of(8'hA5, pred_pc)];
        check("R5 restore wins over shift", int'(pred_hist), 'hA5);
        check("R3 saturating counter direction", pred_taken, int'(exp >= 2));
        if (exp == 3) begin
          pred_valid = 1'b0;
          #0.2;
          check("R8 no lookup no taken", pred_taken, 0);
          pred_valid = 1'b1;
        end
      end
    end

    // R7: lookup and training hit the same counter in one cycle
    for (int k = 0; k < 6; k++) begin
      int exp_old;
      @(negedge clk);
      pred_pc = 32'h4;
      upd_valid = 1'b1; upd_pc = 32'hFFF0_0006; upd_hist = m_hist; upd_taken = 1'b1;
      #1;
      exp_old = model[idx_of(m_hist, pred_pc)];
      check("R7 lookup sees pre-update value", pred_taken, int'(exp_old >= 2));
      model_train(upd_pc, upd_hist, 1'b1, 1'b0, '0, 1'b0);
      @(posedge clk);
      #0.5;
      upd_valid = 1'b0;
      check("R4 outcome shifted into history", int'(pred_hist), int'(m_hist));
    end

    // R1/R2/R3/R4/R5/R7: random training against the model
    for (int it = 0; it < 4000; it++) begin
      logic fx;
      @(negedge clk);
      pred_pc = $urandom;
      upd_valid = ($urandom_range(3) != 0);
      upd_pc = ($urandom_range(1) != 0) ? pred_pc ^ 32'hFF00_0003 : $urandom;
      upd_hist = ($urandom_range(1) != 0) ? m_hist : HIST_W'($urandom);
      upd_taken = $urandom_range(1);
      fx = ($urandom_range(7) == 0);
      fix_valid = fx;
      fix_hist = $urandom;
      fix_taken = $urandom_range(1);
      #1;
      check("R1 R2 lookup matches model", pred_taken,
            int'(model[idx_of(m_hist, pred_pc)] >= 2));
      check("R8 pred_hist is live history", int'(pred_hist), int'(m_hist));
      if (upd_valid) begin
        model_train(upd_pc, upd_hist, upd_taken, fx, fix_hist, fix_taken);
      end else if (fx) begin
        m_hist = {fix_hist[HIST_W-2:0], fix_taken};
      end
    end
    @(negedge clk);
    upd_valid = 1'b0; fix_valid = 1'b0;
    #1;
    check("R4 final history", int'(pred_hist), int'(m_hist));

    // R1: address bits outside the index select the same counter
    for (int p = 0; p < 16; p++) begin
      int exp;
      pred_pc = PC_W'(p) << 2;
      #0.05;
      exp = int'(model[idx_of(m_hist, pred_pc)] >= 2);
      pred_pc = pred_pc ^ 32'h8000_0003 ^ (PC_W'(p) << 12);
      #0.05;
      check("R1 upper and low PC bits ignored", pred_taken, exp);
    end

    finish_run();
  end

endmodule